// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block sequences a charge-redistribution successive-approximation converter that has an N-bit binary-weighted capacitor array. The array also has one terminating unit capacitor, which stays grounded and so has no control bit. After a start pulse, the controller first closes the sample switch so that the input charges the array. It then opens the sample switch and isolates the top plate for one hold cycle. Then it runs one redistribution trial per bit, beginning with the most significant bit.

In each trial the plate-select word switches the chosen capacitors to the reference. The comparator answers whether the held input is at or above the level that word sets. The bit under test is kept when the answer is yes and cleared when it is no. The next lower weight is then switched in for the following trial. When the last bit is resolved, the word is copied to the result register, a one-cycle done strobe is raised, and the array returns to ground.

Top module: `sar_conv_ctrl`

## Requirements
- R1: While reset is high and on the cycle after it, samp_sw, hold_sw and done are 0, and plate_sel and result are all zeros (all plates grounded).
- R2: A start accepted while idle raises samp_sw for exactly SAMPLE_CYC consecutive cycles (minimum 1), starting on the cycle after the accepting edge.
- R3: samp_sw and hold_sw are never both 1 in the same cycle.
- R4: For the one cycle right after sampling, hold_sw is 1 and plate_sel is all zeros. In the next cycle plate_sel has only bit N-1 set, which is the half-scale trial.
- R5: In each trial, the lowest set bit of plate_sel is the bit under test. On the next cycle that bit is kept if cmp_ge was 1 and cleared if it was 0. Bits above it are unchanged, and the next lower bit is set if one remains.
- R6: When bit 0 has been decided, done is 1 for exactly one cycle. In that same cycle result holds the decided word, plate_sel returns to all zeros and hold_sw falls.
- R7: done rises SAMPLE_CYC+N+1 clock edges after the edge that accepts start, with hold_sw high for N+1 cycles before it.
- R8: A start pulse while a conversion is in progress is ignored. The conversion keeps its timing and result, and no new sample phase follows it.
- R9: With an ideal comparator (cmp_ge = input code >= plate_sel), the result equals the input code for every code from all zeros to all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a conversion when idle |
| cmp_ge | input | 1 | Comparator: 1 when input is at or above trial level |
| samp_sw | output | 1 | Sample switch control |
| hold_sw | output | 1 | Top-plate isolate switch control |
| plate_sel | output | N | Per-capacitor select, 1 = reference, 0 = ground |
| result | output | N | Last conversion result |
| done | output | 1 | One-cycle strobe when result updates |

## Verification
The assertions take it that cmp_ge is a function of the plate-select word that is present in the same cycle. They also take it that start is a clean synchronous level. The bench keeps to both. Its comparator model is combinational on plate_sel and a held integer input code, and start is driven only between clock edges. The stray start pulses are placed inside trial phases, where the assertions expect the sequence to continue undisturbed.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SAMPLE = 2'd1,
    PH_HOLD   = 2'd2,
    PH_TRIAL  = 2'd3
  } phase_t;
endpackage

// File: rtl/sar_sequencer.sv
module sar_sequencer #(
  parameter int SAMPLE_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic last_bit,
  output logic samp_sw,
  output logic hold_sw,
  output logic load_msb,
  output logic trial_en
);
  import sar_pkg::*;

  localparam int SC = (SAMPLE_CYC < 1) ? 1 : SAMPLE_CYC;
  localparam int CW = (SC > 1) ? $clog2(SC) : 1;

  phase_t        phase;
  logic [CW-1:0] cnt;

  assign load_msb = (phase == PH_HOLD);
  assign trial_en = (phase == PH_TRIAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      samp_sw <= 1'b0;
      hold_sw <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            phase   <= PH_SAMPLE;
            samp_sw <= 1'b1;
            cnt     <= CW'(SC - 1);
          end
        end
        PH_SAMPLE: begin
          if (cnt == '0) begin
            phase   <= PH_HOLD;
            samp_sw <= 1'b0;
            hold_sw <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_HOLD: phase <= PH_TRIAL;
        PH_TRIAL: begin
          if (last_bit) begin
            phase   <= PH_IDLE;
            hold_sw <= 1'b0;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_msb,
  input  logic         trial_en,
  input  logic         cmp_ge,
  output logic [N-1:0] plate_sel,
  output logic [N-1:0] result,
  output logic         done,
  output logic         last_bit
);
  localparam logic [N-1:0] MSB_ONLY = {1'b1, {(N-1){1'b0}}};

  logic [N-1:0] ptr;
  logic [N-1:0] decided;

  assign last_bit = ptr[0];
  assign decided  = cmp_ge ? plate_sel : (plate_sel & ~ptr);

  always_ff @(posedge clk) begin
    if (rst) begin
      plate_sel <= '0;
      ptr       <= '0;
      result    <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load_msb) begin
        plate_sel <= MSB_ONLY;
        ptr       <= MSB_ONLY;
      end else if (trial_en) begin
        if (ptr[0]) begin
          result    <= decided;
          done      <= 1'b1;
          plate_sel <= '0;
          ptr       <= '0;
        end else begin
          plate_sel <= decided | (ptr >> 1);
          ptr       <= ptr >> 1;
        end
      end
    end
  end
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int N          = 6,
  parameter int SAMPLE_CYC = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         cmp_ge,
  output logic         samp_sw,
  output logic         hold_sw,
  output logic [N-1:0] plate_sel,
  output logic [N-1:0] result,
  output logic         done
);
  logic load_msb;
  logic trial_en;
  logic last_bit;

  sar_sequencer #(.SAMPLE_CYC(SAMPLE_CYC)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .last_bit (last_bit),
    .samp_sw  (samp_sw),
    .hold_sw  (hold_sw),
    .load_msb (load_msb),
    .trial_en (trial_en)
  );

  sar_trial_reg #(.N(N)) u_trial (
    .clk       (clk),
    .rst       (rst),
    .load_msb  (load_msb),
    .trial_en  (trial_en),
    .cmp_ge    (cmp_ge),
    .plate_sel (plate_sel),
    .result    (result),
    .done      (done),
    .last_bit  (last_bit)
  );
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
  parameter int N          = 6,
  parameter int SAMPLE_CYC = 2
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         cmp_ge,
  input logic         samp_sw,
  input logic         hold_sw,
  input logic [N-1:0] plate_sel,
  input logic [N-1:0] result,
  input logic         done
);
  localparam int SC = (SAMPLE_CYC < 1) ? 1 : SAMPLE_CYC;
  localparam logic [N-1:0] MSB_ONLY = {1'b1, {(N-1){1'b0}}};

  logic [N-1:0] lowbit;
  int unsigned  samp_run;

  assign lowbit = plate_sel & (~plate_sel + 1'b1);

  always_ff @(posedge clk) begin
    if (rst) samp_run <= 0;
    else if (samp_sw) samp_run <= samp_run + 1;
    else samp_run <= 0;
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!samp_sw && !hold_sw && !done && plate_sel == '0 && result == '0));

  assert_sample_len_R2: assert property (@(posedge clk) disable iff (rst)
    samp_run <= SC);

  assert_sample_full_R2: assert property (@(posedge clk) disable iff (rst)
    (samp_sw && samp_run < SC - 1) |=> samp_sw);

  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (rst)
    !(samp_sw && hold_sw));

  assert_first_trial_R4: assert property (@(posedge clk) disable iff (rst)
    (hold_sw && plate_sel == '0) |=> (hold_sw && plate_sel == MSB_ONLY));

  assert_trial_step_R5: assert property (@(posedge clk) disable iff (rst)
    (hold_sw && plate_sel != '0 && !lowbit[0]) |=>
      (plate_sel == (($past(cmp_ge) ? $past(plate_sel) : ($past(plate_sel) & ~$past(lowbit)))
                     | ($past(lowbit) >> 1))));

  assert_final_R6: assert property (@(posedge clk) disable iff (rst)
    (hold_sw && lowbit[0]) |=>
      (done && !hold_sw && plate_sel == '0 && result == {$past(plate_sel[N-1:1]), $past(cmp_ge)}));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_no_restart_R8: assert property (@(posedge clk) disable iff (rst)
    (hold_sw && start) |=> !samp_sw);
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.N(N), .SAMPLE_CYC(SAMPLE_CYC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .cmp_ge    (cmp_ge),
  .samp_sw   (samp_sw),
  .hold_sw   (hold_sw),
  .plate_sel (plate_sel),
  .result    (result),
  .done      (done)
);

// File: tb/sar_conv_ctrl_test.sv
module sar_conv_ctrl_test;
  localparam int N  = 6;
  localparam int SC = 2;
  localparam int NCODES = 1 << N;
  localparam logic [N-1:0] MSB_ONLY = {1'b1, {(N-1){1'b0}}};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         cmp_ge;
  logic         samp_sw, hold_sw, done;
  logic [N-1:0] plate_sel, result;
  logic [N-1:0] ain = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [N-1:0] expq[$];

  always #10 clk = ~clk;

  assign cmp_ge = (ain >= plate_sel);

  sar_conv_ctrl #(.N(N), .SAMPLE_CYC(SC)) uut (
    .clk(clk), .rst(rst), .start(start), .cmp_ge(cmp_ge),
    .samp_sw(samp_sw), .hold_sw(hold_sw), .plate_sel(plate_sel),
    .result(result), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: pop expected result whenever done is seen
  always @(negedge clk) begin
    if (!rst && done) begin
      if (expq.size() == 0) chk(0, "R6 unexpected done", 1, 0);
      else begin
        logic [N-1:0] e;
        e = expq.pop_front();
        chk(result == e, "R9 result", result, e);
      end
    end
  end

  task automatic convert(input logic [N-1:0] code, input bit stray);
    ain = code;
    expq.push_back(code);
    start = 1'b1;
    for (int k = 1; k <= SC + N + 2; k++) begin
      @(negedge clk);
      start = (stray && (k == SC + 3)) ? 1'b1 : 1'b0;
      chk(samp_sw == (k <= SC), "R2 samp_sw", samp_sw, k <= SC);
      chk(hold_sw == (k > SC && k <= SC + 1 + N), "R7 hold_sw", hold_sw, (k > SC && k <= SC + 1 + N));
      chk(!(samp_sw && hold_sw), "R3 overlap", samp_sw & hold_sw, 0);
      chk(done == (k == SC + N + 2), "R7 done timing", done, k == SC + N + 2);
      if (k == SC + 1) chk(plate_sel == '0, "R4 hold plates", plate_sel, 0);
      if (k == SC + 2) chk(plate_sel == MSB_ONLY, "R4 first trial", plate_sel, MSB_ONLY);
      if (k == SC + 3) chk(plate_sel == ((code & MSB_ONLY) | (MSB_ONLY >> 1)), "R5 second trial",
                           plate_sel, (code & MSB_ONLY) | (MSB_ONLY >> 1));
      if (k == SC + N + 2) chk(plate_sel == '0, "R6 plates released", plate_sel, 0);
    end
    start = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R6 done single cycle", done, 0);
    if (stray) chk(samp_sw == 1'b0, "R8 stray start ignored", samp_sw, 0);
    chk(result == code, "R6 result held", result, code);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!samp_sw && !hold_sw && !done, "R1 reset controls", {samp_sw, hold_sw, done}, 0);
    chk(plate_sel == '0 && result == '0, "R1 reset plates", plate_sel, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!samp_sw && plate_sel == '0, "R1 idle after reset", plate_sel, 0);
    // R9 full sweep, every code including 0 and all ones
    for (int c = 0; c < NCODES; c++) convert(N'(c), 1'b0);
    // R8 stray starts during trials
    convert('0, 1'b1);
    convert({N{1'b1}}, 1'b1);
    convert(N'(NCODES / 2 - 1), 1'b1);
    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "R6 all results seen", expq.size(), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule